// File: doc/BRIEF.md
# PLL Reconfiguration Control Sequencer

This block owns the 32-bit control word of a clock PLL and steps it through enable, disable and factor-change procedures in hardware, so that no processor has to poll the lock flag. A requester presents one command at a time on a valid/ready handshake: turn the PLL on, turn it off, load new divider codes, or a no-operation. The sequencer writes the control word, produces a one-cycle reset pulse where the procedure needs one, and then watches the PLL lock flag. It checks the flag once per check interval and gives up after a bounded number of intervals.

A factor change runs in one of two modes, chosen per command. In relock mode the new codes are written with the enable state kept, and the reset-and-lock procedure follows. In gated mode the codes are written and the PLL is switched off in the same write, with no lock wait. This gated mode suits clocks that must be stopped before their dividers move. The check interval grows with the reference divider, because a PLL with a slower comparison clock needs longer to settle. Computing the factors, the analog PLL and any register bus sit outside the block.

Top module: `pll_reconfig_seq`

## Requirements
- R1: The control word layout is as follows. Bit 0 is enable and bit 1 is the PLL reset. Bits 7:2 hold the reference divider code, bits 20:8 the feedback multiplier code and bits 24:21 the output divider code, each code being the divider value minus one. Bit 30 is bypass. Bits 30 and 29:25 are never altered by any command, and bit 31 is always driven 0 because lock arrives on its own input.
- R2: `cmd_ready` is high only while the sequencer is idle. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `busy` is high from the cycle after acceptance through the cycle in which `done` or `err_timeout` is high. Each of those two pulses lasts exactly one cycle, and the two never coincide.
- R3: An enable command (`cmd_op`=0) that finds bit 0 already set leaves the word unchanged and raises `done` in the first cycle after acceptance.
- R4: An enable command that finds bit 0 clear sets bit 0 at the acceptance edge. It sets bit 1 one edge later and clears bit 1 on the edge after that, so bit 1 is high for exactly one cycle. Lock polling then starts.
- R5: A check interval lasts CHECK_UNIT × (reference divider code + 1) cycles. `pll_lock` is sampled only on the last edge of each interval. `done` rises in the cycle after the first sample that finds lock set, which gives a latency of 3 + interval × (number of intervals) cycles from acceptance.
- R6: If LOCK_RETRIES consecutive samples all find lock clear, `err_timeout` rises in the cycle after the last sample. The control word keeps its enable bit.
- R7: A relock-mode factor command (`cmd_op`=2, `cmd_gated`=0) replaces the three divider codes and keeps every other bit, enable included. It then runs the reset-and-lock procedure of R4 and R5.
- R8: A gated-mode factor command (`cmd_op`=2, `cmd_gated`=1) writes the three codes and clears bit 0 in one edge. It produces no reset pulse and raises `done` in the first cycle after acceptance.
- R9: A disable command (`cmd_op`=1) clears only bit 0 and raises `done` in the first cycle after acceptance.
- R10: The reserved command code (`cmd_op`=3) changes nothing and raises `done` in the first cycle after acceptance.
- R11: While `rst_n` is low the word takes CTL_INIT with bits 1 and 31 cleared. `cmd_ready` is high and `busy`, `done` and `err_timeout` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; also times the check intervals |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle, command can be taken |
| cmd_op | input | 2 | 0 enable, 1 disable, 2 load factors, 3 no-operation |
| cmd_gated | input | 1 | Factor load mode: 1 gated, 0 relock |
| cmd_nr | input | 6 | Reference divider code (value minus one) |
| cmd_nf | input | 13 | Feedback multiplier code (value minus one) |
| cmd_od | input | 4 | Output divider code (value minus one) |
| pll_lock | input | 1 | Lock flag from the PLL |
| pll_ctl | output | 32 | Control word driven to the PLL |
| busy | output | 1 | A command is in progress |
| done | output | 1 | One-cycle pulse: command completed |
| err_timeout | output | 1 | One-cycle pulse: lock not seen within the retry bound |

## Verification
Two events can land on the same edge: lock appearing at the last permitted sample, and the retry budget running out. That edge decides between `done` and `err_timeout`. The bench's PLL stub raises lock exactly one cycle before the final sample in one run, and exactly on it in another. The first run must end in `done` and the second in `err_timeout`, both with a latency of 3 + interval × LOCK_RETRIES cycles. A cycle-accurate behavioural model follows the word and the status outputs on every clock to confirm which outcome was taken.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;

  // control word bit map (fixed: the PLL decodes these positions)
  localparam int EN_BIT   = 0;
  localparam int RST_BIT  = 1;
  localparam int NR_LSB   = 2;
  localparam int NR_W     = 6;
  localparam int NF_LSB   = 8;
  localparam int NF_W     = 13;
  localparam int OD_LSB   = 21;
  localparam int OD_W     = 4;
  localparam int BYP_BIT  = 30;
  localparam int LOCK_BIT = 31;

  typedef enum logic [1:0] {
    OP_ENABLE  = 2'd0,
    OP_DISABLE = 2'd1,
    OP_FACTORS = 2'd2,
    OP_NOP     = 2'd3
  } seq_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PULSE,
    ST_HOLD,
    ST_POLL,
    ST_DONE,
    ST_FAIL
  } seq_state_e;

  // cycles in one lock-check interval
  function automatic int unsigned check_len(input logic [NR_W-1:0] nr_code,
                                            input int unsigned unit);
    return unit * (int'(nr_code) + 1);
  endfunction

  // replace the three divider codes, keep every other bit
  function automatic logic [31:0] put_factors(input logic [31:0] word,
                                              input logic [NR_W-1:0] nr,
                                              input logic [NF_W-1:0] nf,
                                              input logic [OD_W-1:0] od);
    logic [31:0] w;
    w = word;
    w[NR_LSB +: NR_W] = nr;
    w[NF_LSB +: NF_W] = nf;
    w[OD_LSB +: OD_W] = od;
    return w;
  endfunction

endpackage

// File: rtl/pllseq_ctlreg.sv
module pllseq_ctlreg
  import pllseq_pkg::*;
#(
  parameter logic [31:0] CTL_INIT = 32'h0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_set,
  input  logic            en_clr,
  input  logic            fld_wr,
  input  logic            rst_set,
  input  logic            rst_clr,
  input  logic [NR_W-1:0] nr,
  input  logic [NF_W-1:0] nf,
  input  logic [OD_W-1:0] od,
  output logic [31:0]     word
);

  localparam logic [31:0] CLEAN_MASK = ~((32'h1 << LOCK_BIT) | (32'h1 << RST_BIT));
  localparam logic [31:0] INIT_CLEAN = CTL_INIT & CLEAN_MASK;

  logic [31:0] word_q;
  logic [31:0] word_d;

  always_comb begin
    word_d = word_q;
    if (fld_wr)  word_d = put_factors(word_d, nr, nf, od);
    if (en_set)  word_d[EN_BIT]  = 1'b1;
    if (en_clr)  word_d[EN_BIT]  = 1'b0;
    if (rst_set) word_d[RST_BIT] = 1'b1;
    if (rst_clr) word_d[RST_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) word_q <= INIT_CLEAN;
    else        word_q <= word_d;
  end

  assign word = word_q;

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_q[RST_BIT] |=> !word_q[RST_BIT]); // R4

  AST_KEEP_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(word_q[30:25]) && !word_q[LOCK_BIT]); // R1

endmodule

// File: rtl/pllseq_lockwait.sv
module pllseq_lockwait
  import pllseq_pkg::*;
#(
  parameter int unsigned CHECK_UNIT   = 500,
  parameter int unsigned LOCK_RETRIES = 50,
  parameter int          CNT_W        = 16,
  parameter int          TRY_W        = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NR_W-1:0] nr_code,
  input  logic            lock,
  output logic            hit,
  output logic            expired
);

  logic             running;
  logic [CNT_W-1:0] cnt;
  logic [TRY_W-1:0] tries;
  logic             sample;
  logic             last_try;
  logic [CNT_W-1:0] reload;

  assign reload   = CNT_W'(check_len(nr_code, CHECK_UNIT) - 1);
  assign sample   = running && (cnt == '0);
  assign last_try = (tries == TRY_W'(LOCK_RETRIES - 1));
  assign hit      = sample && lock;
  assign expired  = sample && !lock && last_try;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      tries   <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= reload;
      tries   <= '0;
    end else if (sample) begin
      if (hit || expired) begin
        running <= 1'b0;
      end else begin
        tries <= tries + 1'b1;
        cnt   <= reload;
      end
    end else if (running) begin
      cnt <= cnt - 1'b1;
    end
  end

  AST_TRIES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (tries < TRY_W'(LOCK_RETRIES))); // R6

  AST_IDLE_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !hit && !expired); // R5

endmodule

// File: rtl/pllseq_fsm.sv
module pllseq_fsm
  import pllseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  input  logic       cmd_gated,
  input  logic       en_now,
  input  logic       hit,
  input  logic       expired,
  output logic       cmd_ready,
  output logic       busy,
  output logic       done,
  output logic       err,
  output logic       en_set,
  output logic       en_clr,
  output logic       fld_wr,
  output logic       rst_set,
  output logic       rst_clr,
  output logic       wait_start
);

  seq_state_e state_q, state_d;
  seq_op_e    op;
  logic       accept;

  assign op     = seq_op_e'(cmd_op);
  assign accept = cmd_valid && (state_q == ST_IDLE);

  always_comb begin
    state_d    = state_q;
    en_set     = 1'b0;
    en_clr     = 1'b0;
    fld_wr     = 1'b0;
    rst_set    = 1'b0;
    rst_clr    = 1'b0;
    wait_start = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          unique case (op)
            OP_ENABLE: begin
              if (en_now) begin
                state_d = ST_DONE;
              end else begin
                en_set  = 1'b1;
                state_d = ST_PULSE;
              end
            end
            OP_DISABLE: begin
              en_clr  = 1'b1;
              state_d = ST_DONE;
            end
            OP_FACTORS: begin
              fld_wr = 1'b1;
              if (cmd_gated) begin
                en_clr  = 1'b1;
                state_d = ST_DONE;
              end else begin
                state_d = ST_PULSE;
              end
            end
            default: state_d = ST_DONE;
          endcase
        end
      end
      ST_PULSE: begin
        rst_set = 1'b1;
        state_d = ST_HOLD;
      end
      ST_HOLD: begin
        rst_clr    = 1'b1;
        wait_start = 1'b1;
        state_d    = ST_POLL;
      end
      ST_POLL: begin
        if (hit)          state_d = ST_DONE;
        else if (expired) state_d = ST_FAIL;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_DONE);
  assign err       = (state_q == ST_FAIL);

  AST_POLL_ONLY_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_POLL) |-> (($past(state_q) == ST_HOLD) || ($past(state_q) == ST_POLL))); // R4

endmodule

// File: rtl/pll_reconfig_seq.sv
module pll_reconfig_seq
  import pllseq_pkg::*;
#(
  parameter int unsigned CHECK_UNIT   = 500,
  parameter int unsigned LOCK_RETRIES = 50,
  parameter logic [31:0] CTL_INIT     = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [1:0]  cmd_op,
  input  logic        cmd_gated,
  input  logic [5:0]  cmd_nr,
  input  logic [12:0] cmd_nf,
  input  logic [3:0]  cmd_od,
  input  logic        pll_lock,
  output logic [31:0] pll_ctl,
  output logic        busy,
  output logic        done,
  output logic        err_timeout
);

  localparam int unsigned LEN_MAX = CHECK_UNIT * (2 ** NR_W);
  localparam int          CNT_W   = $clog2(LEN_MAX + 1);
  localparam int          TRY_W   = $clog2(LOCK_RETRIES + 1);

  // named internal events
  logic en_set, en_clr, fld_wr, rst_set, rst_clr, wait_start;
  logic lock_hit, lock_expired;
  logic accept;

  assign accept = cmd_valid && cmd_ready;

  pllseq_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_gated  (cmd_gated),
    .en_now     (pll_ctl[EN_BIT]),
    .hit        (lock_hit),
    .expired    (lock_expired),
    .cmd_ready  (cmd_ready),
    .busy       (busy),
    .done       (done),
    .err        (err_timeout),
    .en_set     (en_set),
    .en_clr     (en_clr),
    .fld_wr     (fld_wr),
    .rst_set    (rst_set),
    .rst_clr    (rst_clr),
    .wait_start (wait_start)
  );

  pllseq_ctlreg #(.CTL_INIT(CTL_INIT)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_set  (en_set),
    .en_clr  (en_clr),
    .fld_wr  (fld_wr),
    .rst_set (rst_set),
    .rst_clr (rst_clr),
    .nr      (cmd_nr),
    .nf      (cmd_nf),
    .od      (cmd_od),
    .word    (pll_ctl)
  );

  pllseq_lockwait #(
    .CHECK_UNIT   (CHECK_UNIT),
    .LOCK_RETRIES (LOCK_RETRIES),
    .CNT_W        (CNT_W),
    .TRY_W        (TRY_W)
  ) u_wait (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (wait_start),
    .nr_code (pll_ctl[NR_LSB +: NR_W]),
    .lock    (pll_lock),
    .hit     (lock_hit),
    .expired (lock_expired)
  );

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy && !cmd_ready); // R2

  AST_END_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (done || err_timeout) |=> !busy && cmd_ready && !done && !err_timeout); // R2

  AST_ENABLE_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op == 2'd0 && pll_ctl[EN_BIT]) |=> done && $stable(pll_ctl)); // R3

  AST_DISABLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op == 2'd1) |=> done && !pll_ctl[EN_BIT] && (pll_ctl[31:1] == $past(pll_ctl[31:1]))); // R9

  AST_GATED_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && cmd_op == 2'd2 && cmd_gated) |=> done && !pll_ctl[EN_BIT] && !pll_ctl[RST_BIT]); // R8

  AST_TIMEOUT_NOLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |-> !$past(pll_lock) && pll_ctl[EN_BIT]); // R6

endmodule

// File: tb/test_pll_reconfig_seq.sv
`timescale 1ns/1ps
module test_pll_reconfig_seq;

  localparam int unsigned UNIT    = 4;
  localparam int unsigned RETRIES = 50;
  localparam logic [31:0] INIT    = 32'h4800_0000; // bypass + one reserved bit

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'd0;
  logic        cmd_gated = 1'b0;
  logic [5:0]  cmd_nr = '0;
  logic [12:0] cmd_nf = '0;
  logic [3:0]  cmd_od = '0;
  logic        pll_lock = 1'b0;
  logic [31:0] pll_ctl;
  logic        busy, done, err_timeout;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int lock_delay = 10;
  int stub_rem = 0;

  always #10 clk = ~clk; // 50 MHz

  pll_reconfig_seq #(
    .CHECK_UNIT   (UNIT),
    .LOCK_RETRIES (RETRIES),
    .CTL_INIT     (INIT)
  ) i_pll_reconfig_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_gated(cmd_gated), .cmd_nr(cmd_nr), .cmd_nf(cmd_nf),
    .cmd_od(cmd_od), .pll_lock(pll_lock), .pll_ctl(pll_ctl), .busy(busy),
    .done(done), .err_timeout(err_timeout)
  );

  // behavioural PLL: lock drops on reset pulse or disable, rises after lock_delay edges
  always @(posedge clk) begin
    if (!pll_ctl[0] || pll_ctl[1]) begin
      pll_lock <= 1'b0;
      stub_rem <= lock_delay;
    end else if (stub_rem <= 1) begin
      pll_lock <= 1'b1;
    end else begin
      stub_rem <= stub_rem - 1;
    end
  end

  // cycle-accurate reference model
  int          m_phase = 0; // 0 idle 1 pulse 2 hold 3 poll 4 done 5 fail
  int          m_left = 0;
  int          m_tries = 0;
  logic [31:0] m_word = 32'h0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_word  <= INIT & 32'h7FFF_FFFD;
      m_phase <= 0;
    end else begin
      case (m_phase)
        0: if (cmd_valid) begin
          automatic logic [31:0] w = m_word;
          case (cmd_op)
            2'd0: if (w[0]) m_phase <= 4; else begin w[0] = 1'b1; m_phase <= 1; end
            2'd1: begin w[0] = 1'b0; m_phase <= 4; end
            2'd2: begin
              w = (w & ~32'h01FF_FFFC) | (32'(cmd_nr) << 2) | (32'(cmd_nf) << 8) | (32'(cmd_od) << 21);
              if (cmd_gated) begin w[0] = 1'b0; m_phase <= 4; end
              else m_phase <= 1;
            end
            default: m_phase <= 4;
          endcase
          m_word <= w;
        end
        1: begin m_word[1] <= 1'b1; m_phase <= 2; end
        2: begin
          m_word[1] <= 1'b0;
          m_left    <= int'(UNIT) * (int'(m_word[7:2]) + 1);
          m_tries   <= 0;
          m_phase   <= 3;
        end
        3: begin
          if (m_left > 1) m_left <= m_left - 1;
          else if (pll_lock) m_phase <= 4;
          else if (m_tries + 1 == int'(RETRIES)) m_phase <= 5;
          else begin
            m_tries <= m_tries + 1;
            m_left  <= int'(UNIT) * (int'(m_word[7:2]) + 1);
          end
        end
        default: m_phase <= 0;
      endcase
    end
  end

  // per-cycle comparison (R1, R2 and the sequence requirements)
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      checks++;
      if (pll_ctl !== m_word || cmd_ready !== (m_phase == 0) || busy !== (m_phase != 0) ||
          done !== (m_phase == 4) || err_timeout !== (m_phase == 5)) begin
        errors++;
        $display("FAIL R2 model: ctl=%h rdy=%b busy=%b done=%b err=%b exp ctl=%h phase=%0d",
                 pll_ctl, cmd_ready, busy, done, err_timeout, m_word, m_phase);
      end
    end
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_word(input logic [31:0] base, input bit en,
                                          input int nr, input int nf, input int od);
    logic [31:0] w;
    w = (base & ~32'h01FF_FFFF) | (32'(nr) << 2) | (32'(nf) << 8) | (32'(od) << 21);
    w[0] = en;
    return w;
  endfunction

  // issue a command; return latency and which end pulse was seen
  task automatic issue(input logic [1:0] op, input bit gated, input int nr, input int nf,
                       input int od, output int lat, output bit saw_done);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_gated = gated;
    cmd_nr = 6'(nr); cmd_nf = 13'(nf); cmd_od = 4'(od);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    lat = 1;
    while (!done && !err_timeout && lat < 5000) begin
      @(negedge clk);
      lat++;
    end
    saw_done = done;
  endtask

  int    lat;
  bit    sd;
  logic [31:0] w_exp;

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(pll_ctl == 32'h4800_0000, "R11 word", pll_ctl, 32'h4800_0000);
    chk(cmd_ready && !busy && !done && !err_timeout, "R11 flags",
        {cmd_ready, busy, done, err_timeout}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 R5: enable from off, nr code 0 -> interval 4, lock after 20 -> 6 intervals
    lock_delay = 20;
    issue(2'd0, 1'b0, 0, 0, 0, lat, sd);
    chk(sd, "R4 enable ends in done", 32'(sd), 1);
    chk(lat == 3 + 4 * 6, "R5 enable latency", lat, 3 + 4 * 6);
    chk(pll_ctl == 32'h4800_0001, "R4 enable word", pll_ctl, 32'h4800_0001);

    // R3: enable while already on
    w_exp = pll_ctl;
    issue(2'd0, 1'b0, 9, 9, 9, lat, sd);
    chk(sd && lat == 1, "R3 immediate done", lat, 1);
    chk(pll_ctl == w_exp, "R3 word untouched", pll_ctl, w_exp);

    // R7: relock factor load, nr code 3 -> interval 16, lock after 40 -> 3 intervals
    lock_delay = 40;
    issue(2'd2, 1'b0, 3, 13'h1A5, 5, lat, sd);
    w_exp = mk_word(32'h4800_0000, 1'b1, 3, 13'h1A5, 5);
    chk(pll_ctl == w_exp, "R7 fields and enable kept", pll_ctl, w_exp);
    chk(sd && lat == 3 + 16 * 3, "R7 relock latency", lat, 3 + 16 * 3);

    // R8: gated factor load
    issue(2'd2, 1'b1, 1, 7, 2, lat, sd);
    w_exp = mk_word(32'h4800_0000, 1'b0, 1, 7, 2);
    chk(pll_ctl == w_exp, "R8 gated word", pll_ctl, w_exp);
    chk(sd && lat == 1, "R8 no lock wait", lat, 1);

    // R10: reserved op
    w_exp = pll_ctl;
    issue(2'd3, 1'b0, 63, 13'h1FFF, 15, lat, sd);
    chk(sd && lat == 1 && pll_ctl == w_exp, "R10 no-op", pll_ctl, w_exp);

    // R5 corner: lock shows one cycle before the last permitted sample (interval 8)
    lock_delay = 8 * RETRIES - 1;
    issue(2'd0, 1'b0, 0, 0, 0, lat, sd);
    chk(sd, "R5 lock at last sample gives done", 32'(sd), 1);
    chk(lat == 3 + 8 * RETRIES, "R5 last-sample latency", lat, 3 + 8 * RETRIES);

    // R9: disable keeps everything else
    w_exp = pll_ctl & ~32'h1;
    issue(2'd1, 1'b0, 0, 0, 0, lat, sd);
    chk(sd && lat == 1 && pll_ctl == w_exp, "R9 disable", pll_ctl, w_exp);

    // R6: lock arrives exactly at the final sample edge -> timeout
    lock_delay = 8 * RETRIES;
    issue(2'd0, 1'b0, 0, 0, 0, lat, sd);
    chk(!sd && err_timeout, "R6 timeout raised", 32'(err_timeout), 1);
    chk(lat == 3 + 8 * RETRIES, "R6 timeout latency", lat, 3 + 8 * RETRIES);
    chk(pll_ctl[0] && pll_ctl[30], "R6 R1 enable and bypass kept", pll_ctl, 32'h4800_0001);
    @(negedge clk);
    chk(!err_timeout && !busy && cmd_ready, "R2 pulse one cycle", {busy, err_timeout}, 0);

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule